// File: doc/BRIEF.md
# Serial Converter Digital Interface Emulator

This block stands in for the digital side of a 14-bit serial sampling converter so that a host controller can be exercised without any analog hardware. The host starts a conversion with a falling edge on an active-low convert-start line. The block then holds a busy flag for a programmable number of clock cycles, after which the result can be shifted out with an external serial clock. The result is a sample word that the environment loads on a parallel input and that the block captures when the conversion starts.

The frame is sixteen bits long: two zero bits, then the 14-bit result MSB first. A new bit appears after each falling serial-clock edge. After the sixteenth falling edge the last bit stays on the line for a few cycles, then the output enable drops so an external pad can float the line. If convert-start is still low when the conversion finishes, the block enters a power-down state. A later rising edge on convert-start starts a wake-up period, and busy stays high during it. Falling edges on convert-start that arrive while busy is high are ignored and counted.

Both convert-start and the serial clock are asynchronous to the system clock. Each passes through a synchronizer of configurable depth, so the block reacts SYNC_STAGES+1 clock edges after an input changes.

Top module: `adc_serial_emu`

## Requirements
- R1: Out of reset busy is 0, the serial output enable is 0, the data bit is 0 and the violation count is 0.
- R2: A convert-start falling edge seen while idle captures the sample and raises busy SYNC_STAGES+1 clock edges later. Busy then stays high for exactly CONV_CYCLES cycles.
- R3: If convert-start is low when the conversion ends, busy falls and stays low for as long as convert-start stays low. A later rising edge raises busy for exactly WAKE_CYCLES cycles, after which the block is idle.
- R4: If convert-start is high when the conversion ends, the block is idle at once. The next falling edge starts a conversion with no wake-up period, so busy is again high for exactly CONV_CYCLES cycles.
- R5: In the cycle in which busy falls at the end of a conversion, the output enable is 1 and the data bit is the first leading zero. Each falling serial-clock edge then advances one bit through the 16-bit frame, which is 00 followed by the 14-bit result MSB first. Rising serial-clock edges have no effect.
- R6: After the sixteenth falling serial-clock edge the last result bit is held for HOLD_CYCLES cycles, then the output enable goes to 0. Further serial-clock edges leave it at 0 until the next conversion ends.
- R7: With code_mode = 0 the 14-bit result equals the captured sample, taken as a twos-complement value. With code_mode = 1 it is the straight-binary form of that value, which is the sample with its MSB inverted. The mode is sampled together with the sample.
- R8: A convert-start falling edge seen while busy is high starts nothing and leaves the captured sample unchanged. Each such edge adds 1 to the violation count, which saturates at its maximum value.
- R9: The end of a conversion that comes during a frame still being read restarts the output at the first leading zero of the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start_n | input | 1 | Convert-start, active-low and edge-triggered (asynchronous) |
| sclk | input | 1 | External serial clock; bits change on its falling edge (asynchronous) |
| sample_in | input | DATA_W | Twos-complement sample captured when a conversion starts |
| code_mode | input | 1 | 0: twos-complement output, 1: straight-binary output |
| busy | output | 1 | High during conversion and wake-up |
| sdata_o | output | 1 | Serial data bit, 0 while disabled |
| sdata_oe | output | 1 | Output enable for the external tri-state data pad |
| viol_cnt | output | VIOL_W | Saturating count of convert-start edges ignored while busy |

## Verification
The bench measures the exact length of busy for a conversion that ends in idle, for one that ends in power-down, and for the wake-up that follows. A miscounted counter would show here as a busy pulse one cycle too long or too short, and a wrong end-of-conversion decision as busy coming back without a rising edge. It reads frames in both coding modes and after a conversion that interrupts a half-read frame. A design that skipped the early leading zero, lost a bit or kept a stale bit position would return a shifted word. It also pulses convert-start and changes the sample while busy is high. A design that restarted or recaptured on those edges would return the wrong word or show the wrong busy length, and one that failed to count them would show a flat violation count.

// File: rtl/adc_emu_pkg.sv
// Shared types for the serial converter interface emulator.
package adc_emu_pkg;
    // Conversion control states; busy is high in ST_CONV and ST_WAKE.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_PDOWN = 2'd2,
        ST_WAKE  = 2'd3
    } conv_state_e;
endpackage

// File: rtl/adc_edge_sync.sv
// Synchronizes one asynchronous input into the clk domain.
// Outputs the synchronized level and its value one cycle earlier, so the
// consumer can derive edges. Assumes the input stays stable for at least
// two clk cycles between changes.
module adc_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic last
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the input through the synchronizer chain and keep one extra stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            last_q  <= RST_VAL;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            last_q <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign last  = last_q;
endmodule

// File: rtl/adc_conv_ctrl.sv
// Conversion control: capture on a convert-start fall, conversion timing,
// the power-down decision at the end of conversion, wake-up timing, and
// counting of convert-start edges that arrive while busy.
// Assumes synchronized edge strobes and CONV_CYCLES, WAKE_CYCLES >= 1.
module adc_conv_ctrl
    import adc_emu_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int CONV_CYCLES = 20,
    parameter int WAKE_CYCLES = 12,
    parameter int VIOL_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cv_fall,
    input  logic              cv_rise,
    input  logic              cv_level,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              code_mode,
    output conv_state_e       state,
    output logic              busy,
    output logic              conv_done,
    output logic [DATA_W-1:0] word,
    output logic [VIOL_W-1:0] viol_cnt
);
    localparam int MAXC = (CONV_CYCLES > WAKE_CYCLES) ? CONV_CYCLES : WAKE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYCLES - 1);
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

    conv_state_e       state_q;
    logic [CW-1:0]     cnt_q;
    logic [DATA_W-1:0] word_q;
    logic [VIOL_W-1:0] viol_q;
    logic [DATA_W-1:0] presented;

    // Straight binary is the twos-complement value with its sign bit flipped.
    assign presented = code_mode ? {~sample_in[DATA_W-1], sample_in[DATA_W-2:0]}
                                 : sample_in;

    // Main state machine with one counter shared by conversion and wake-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            word_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cv_fall) begin
                        word_q  <= presented;
                        cnt_q   <= '0;
                        state_q <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (cnt_q == CONV_LAST) begin
                        cnt_q   <= '0;
                        state_q <= cv_level ? ST_IDLE : ST_PDOWN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PDOWN: begin
                    if (cv_rise) begin
                        cnt_q   <= '0;
                        state_q <= ST_WAKE;
                    end
                end
                default: begin
                    if (cnt_q == WAKE_LAST) begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Count convert-start falls that arrive while busy, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= '0;
        end else if (cv_fall && busy && (viol_q != {VIOL_W{1'b1}})) begin
            viol_q <= viol_q + 1'b1;
        end
    end

    assign busy      = (state_q == ST_CONV) || (state_q == ST_WAKE);
    assign conv_done = (state_q == ST_CONV) && (cnt_q == CONV_LAST);
    assign state     = state_q;
    assign word      = word_q;
    assign viol_cnt  = viol_q;
endmodule

// File: rtl/adc_frame_shift.sv
// Serial frame output: loads leading zeros plus the result on load, drives
// the first bit at once, advances on each serial-clock fall, and holds the
// last bit for HOLD_CYCLES before dropping the output enable.
// Assumes HOLD_CYCLES >= 1.
module adc_frame_shift #(
    parameter int DATA_W      = 14,
    parameter int LEAD_ZEROS  = 2,
    parameter int HOLD_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    input  logic              sck_fall,
    output logic              sdata_o,
    output logic              sdata_oe
);
    localparam int FRAME_W = DATA_W + LEAD_ZEROS;
    localparam int BCW     = $clog2(FRAME_W);
    localparam int HW      = $clog2(HOLD_CYCLES + 1);
    localparam logic [BCW-1:0] BIT_LAST  = BCW'(FRAME_W - 1);
    localparam logic [HW-1:0]  HOLD_LAST = HW'(HOLD_CYCLES - 1);

    logic [FRAME_W-1:0] frame_q;
    logic [BCW-1:0]     bcnt_q;
    logic [HW-1:0]      hcnt_q;
    logic               oe_q;
    logic               hold_q;

    // Load, shift, hold and release sequence for one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            bcnt_q  <= '0;
            hcnt_q  <= '0;
            oe_q    <= 1'b0;
            hold_q  <= 1'b0;
        end else if (load) begin
            frame_q <= {{LEAD_ZEROS{1'b0}}, word};
            bcnt_q  <= '0;
            oe_q    <= 1'b1;
            hold_q  <= 1'b0;
        end else if (oe_q && !hold_q && sck_fall) begin
            if (bcnt_q == BIT_LAST) begin
                hold_q <= 1'b1;
                hcnt_q <= '0;
            end else begin
                frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                bcnt_q  <= bcnt_q + 1'b1;
            end
        end else if (hold_q) begin
            if (hcnt_q == HOLD_LAST) begin
                oe_q   <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

    assign sdata_o  = oe_q & frame_q[FRAME_W-1];
    assign sdata_oe = oe_q;
endmodule

// File: rtl/adc_serial_emu.sv
// Top of the serial converter interface emulator. Synchronizes both
// asynchronous inputs, runs conversion control and drives the serial frame.
// The data line is brought out as a bit plus an enable for an external pad.
module adc_serial_emu
    import adc_emu_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int LEAD_ZEROS  = 2,
    parameter int CONV_CYCLES = 20,
    parameter int WAKE_CYCLES = 12,
    parameter int HOLD_CYCLES = 3,
    parameter int SYNC_STAGES = 2,
    parameter int VIOL_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              code_mode,
    output logic              busy,
    output logic              sdata_o,
    output logic              sdata_oe,
    output logic [VIOL_W-1:0] viol_cnt
);
    logic              cv_level, cv_last, sk_level, sk_last;
    logic              cv_fall, cv_rise, sk_fall;
    logic              conv_done;
    logic [DATA_W-1:0] word;
    conv_state_e       state;

    adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) cv_sync_i (
        .clk(clk), .rst_n(rst_n), .din(conv_start_n),
        .level(cv_level), .last(cv_last)
    );

    adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) sk_sync_i (
        .clk(clk), .rst_n(rst_n), .din(sclk),
        .level(sk_level), .last(sk_last)
    );

    assign cv_fall = cv_last & ~cv_level;
    assign cv_rise = ~cv_last & cv_level;
    assign sk_fall = sk_last & ~sk_level;

    adc_conv_ctrl #(
        .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES),
        .WAKE_CYCLES(WAKE_CYCLES), .VIOL_W(VIOL_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .cv_fall(cv_fall), .cv_rise(cv_rise), .cv_level(cv_level),
        .sample_in(sample_in), .code_mode(code_mode),
        .state(state), .busy(busy), .conv_done(conv_done),
        .word(word), .viol_cnt(viol_cnt)
    );

    adc_frame_shift #(
        .DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS), .HOLD_CYCLES(HOLD_CYCLES)
    ) shift_i (
        .clk(clk), .rst_n(rst_n),
        .load(conv_done), .word(word), .sck_fall(sk_fall),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe)
    );
endmodule

// File: rtl/adc_serial_emu_chk.sv
// Protocol checker for adc_serial_emu, attached with bind below.
// It relates the control state and the frame output over time.
module adc_serial_emu_chk
    import adc_emu_pkg::*;
#(
    parameter int VIOL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              sdata_o,
    input logic              sdata_oe,
    input logic              conv_done,
    input logic [VIOL_W-1:0] viol_cnt,
    input conv_state_e       state
);
    // R5: the cycle after a conversion ends carries an enabled leading zero.
    a_r5_first_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (sdata_oe && !sdata_o));

    // R6: the enable only ever rises because a conversion ended.
    a_r6_oe_rise_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> $past(conv_done));

    // R3: busy rises only from idle (conversion) or power-down (wake-up).
    a_r3_busy_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(state) == ST_IDLE || $past(state) == ST_PDOWN));

    // R4: the end of a conversion leads to idle or power-down, never to wake-up.
    a_r4_done_next_state: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (state == ST_IDLE || state == ST_PDOWN));

    // R8: the violation count moves by at most one per cycle and never drops.
    a_r8_viol_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (viol_cnt == $past(viol_cnt) || viol_cnt == $past(viol_cnt) + 1'b1));
endmodule

bind adc_serial_emu adc_serial_emu_chk #(.VIOL_W(VIOL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sdata_o(sdata_o),
    .sdata_oe(sdata_oe), .conv_done(conv_done), .viol_cnt(viol_cnt),
    .state(state)
);

// File: tb/adc_serial_emu_tb_top.sv
// Bench for adc_serial_emu: a behavioural reference model compared on every
// clock, plus directed checks on frames and busy lengths.
module adc_serial_emu_tb_top;
    localparam int CONV = 20;
    localparam int WAKE = 12;
    localparam int HOLD = 3;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start_n = 1'b1;
    logic        sclk = 1'b0;
    logic [13:0] sample_in = '0;
    logic        code_mode = 1'b0;
    logic        busy, sdata_o, sdata_oe;
    logic [7:0]  viol_cnt;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    adc_serial_emu #(
        .CONV_CYCLES(CONV), .WAKE_CYCLES(WAKE), .HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n), .sclk(sclk),
        .sample_in(sample_in), .code_mode(code_mode), .busy(busy),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe), .viol_cnt(viol_cnt)
    );

    // Reference model state.
    bit          cv_dl[$];
    bit          sk_dl[$];
    bit          cv_prev, sk_prev;
    int          m_mode;      // 0 idle, 1 converting, 2 powered down, 3 waking
    int          m_left;      // busy cycles still to come
    bit [13:0]   m_word;
    bit [15:0]   m_frame;
    int          m_pos;
    bit          m_oe;
    int          m_hold_left; // -1 when not holding
    int          m_viol;

    function automatic bit [13:0] to_code(bit [13:0] s, bit mode);
        return mode ? (s ^ 14'h2000) : s;
    endfunction

    // Behavioural model, advanced on each rising clock edge.
    always @(posedge clk) begin
        bit cv_now, sk_now, cvf, cvr, skf, finish_conv;
        if (!rst_n) begin
            cv_dl = {}; sk_dl = {};
            for (int i = 0; i < SYNC; i++) begin cv_dl.push_back(1'b1); sk_dl.push_back(1'b0); end
            cv_prev = 1'b1; sk_prev = 1'b0;
            m_mode = 0; m_left = 0; m_word = '0; m_frame = '0; m_pos = 0;
            m_oe = 0; m_hold_left = -1; m_viol = 0;
        end else begin
            cv_now = cv_dl[SYNC-1];
            sk_now = sk_dl[SYNC-1];
            cvf = cv_prev && !cv_now;
            cvr = !cv_prev && cv_now;
            skf = sk_prev && !sk_now;
            finish_conv = (m_mode == 1) && (m_left == 1);
            if (cvf && (m_mode == 1 || m_mode == 3) && m_viol < 255) m_viol++;
            if (finish_conv) begin
                m_frame = {2'b00, m_word}; m_pos = 0; m_oe = 1; m_hold_left = -1;
            end else if (m_oe && m_hold_left < 0 && skf) begin
                if (m_pos == 15) m_hold_left = HOLD;
                else m_pos++;
            end else if (m_hold_left >= 0) begin
                m_hold_left--;
                if (m_hold_left == 0) begin m_oe = 0; m_hold_left = -1; end
            end
            case (m_mode)
                0: if (cvf) begin m_word = to_code(sample_in, code_mode); m_mode = 1; m_left = CONV; end
                1: begin
                    m_left--;
                    if (m_left == 0) m_mode = cv_now ? 0 : 2;
                end
                2: if (cvr) begin m_mode = 3; m_left = WAKE; end
                default: begin
                    m_left--;
                    if (m_left == 0) m_mode = 0;
                end
            endcase
            cv_prev = cv_now; sk_prev = sk_now;
            void'(cv_dl.pop_back()); cv_dl.push_front(conv_start_n);
            void'(sk_dl.pop_back()); sk_dl.push_front(sclk);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the outputs against the model in the middle of every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_busy;
            exp_busy = (m_mode == 1) || (m_mode == 3);
            check(busy == exp_busy, "R2 busy vs model", busy, exp_busy);
            check(sdata_oe == m_oe, "R6 enable vs model", sdata_oe, m_oe);
            if (m_oe) check(sdata_o == m_frame[15-m_pos], "R5 data vs model", sdata_o, m_frame[15-m_pos]);
            check(viol_cnt == m_viol[7:0], "R8 count vs model", viol_cnt, m_viol);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic conv_pulse();
        @(negedge clk); #2 conv_start_n = 1'b0;
        cyc(3); #2 conv_start_n = 1'b1;
    endtask

    // Returns the number of cycles busy stays high from its next rise.
    task automatic busy_len(output int n);
        n = 0;
        for (int i = 0; i < 60 && !busy; i++) @(negedge clk);
        for (int i = 0; i < 200 && busy; i++) begin n++; @(negedge clk); end
    endtask

    task automatic sclk_fall();
        #2 sclk = 1'b1; cyc(3); #2 sclk = 1'b0;
        cyc(4);
    endtask

    // Read a full 16-bit frame; the first bit is read before any clock.
    task automatic read_frame(output bit [15:0] got);
        got[15] = sdata_o;
        for (int i = 14; i >= 0; i--) begin
            sclk_fall();
            got[i] = sdata_o;
        end
    endtask

    initial begin
        #3000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit [15:0] got;
        int len;
        cyc(5); #2 rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && sdata_oe == 0 && sdata_o == 0 && viol_cnt == 0,
              "R1 reset state", {busy, sdata_oe, sdata_o}, 0);

        // R2, R4, R5, R7: twos-complement frame after a short start pulse.
        sample_in = 14'h2ABC; code_mode = 0;
        conv_pulse();
        busy_len(len);
        check(len == CONV, "R2 conversion busy length", len, CONV);
        check(sdata_oe == 1 && sdata_o == 0, "R5 first zero at busy fall", {sdata_oe, sdata_o}, 2);
        read_frame(got);
        check(got == 16'h2ABC, "R7 twos-complement frame", got, 16'h2ABC);
        sclk_fall();
        check(sdata_oe == 1 && sdata_o == 0, "R6 last bit held", {sdata_oe, sdata_o}, 2);
        cyc(4);
        check(sdata_oe == 0, "R6 enable released", sdata_oe, 0);
        sclk_fall(); sclk_fall();
        check(sdata_oe == 0, "R6 extra clocks ignored", sdata_oe, 0);

        // R4: start again right away; no wake-up period is added.
        conv_pulse();
        busy_len(len);
        check(len == CONV, "R4 back-to-back busy length", len, CONV);

        // R7: straight binary inverts the sign bit.
        sample_in = 14'h0123; code_mode = 1;
        conv_pulse();
        busy_len(len);
        read_frame(got);
        check(got == 16'h2123, "R7 straight-binary frame", got, 16'h2123);
        sclk_fall(); cyc(6);

        // R3: hold convert-start low through the end of the conversion.
        code_mode = 0; sample_in = 14'h1F0F;
        @(negedge clk); #2 conv_start_n = 1'b0;
        busy_len(len);
        check(len == CONV, "R3 conversion before power-down", len, CONV);
        read_frame(got);
        check(got == 16'h1F0F, "R3 frame read in power-down", got, 16'h1F0F);
        check(busy == 0, "R3 busy low in power-down", busy, 0);
        @(negedge clk); #2 conv_start_n = 1'b1;
        busy_len(len);
        check(len == WAKE, "R3 wake-up busy length", len, WAKE);
        cyc(10);

        // R8: edges during conversion and wake-up are counted and ignored.
        sample_in = 14'h0AAA;
        conv_pulse();
        cyc(2); sample_in = 14'h3555;
        conv_pulse();
        conv_pulse();
        busy_len(len);
        check(viol_cnt == 2, "R8 count during conversion", viol_cnt, 2);
        read_frame(got);
        check(got == 16'h0AAA, "R8 sample not recaptured", got, 16'h0AAA);
        sclk_fall(); cyc(6);
        @(negedge clk); #2 conv_start_n = 1'b0;
        busy_len(len);
        @(negedge clk); #2 conv_start_n = 1'b1;
        cyc(5);
        conv_pulse();
        busy_len(len);
        check(viol_cnt == 3, "R8 count during wake-up", viol_cnt, 3);
        check(len + 8 > WAKE && len < WAKE, "R8 wake length unaffected", len, WAKE - 8);
        cyc(5);

        // R9: a conversion ending mid-frame restarts the frame.
        sample_in = 14'h3FFF;
        conv_pulse();
        busy_len(len);
        for (int i = 0; i < 5; i++) sclk_fall();
        sample_in = 14'h1234;
        conv_pulse();
        busy_len(len);
        read_frame(got);
        check(got == 16'h1234, "R9 restarted frame", got, 16'h1234);
        sclk_fall(); cyc(8);
        check(sdata_oe == 0, "R6 released after restart", sdata_oe, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule